// File: doc/BRIEF.md
# PWM Leading-Edge Blanking Unit

This block suppresses an external fault or trigger signal for a programmable number of clock cycles after chosen switching edges of a complementary PWM pair. Switching transients on the high-side and low-side outputs often produce spurious trigger pulses. The unit ignores the trigger input for a short, configurable window that starts on any selected mix of the four possible edges: high-side rising, high-side falling, low-side rising and low-side falling.

A single 32-bit configuration register holds four edge enables and a 7-bit duration field. A write takes effect only while both write-protect flags (software and hardware) are clear. The register reads back at all times. Outside a blanking window the trigger passes to the output one clock cycle later.

Top module: `leb_unit`

## Requirements
- R1: After reset the register reads 0, trig_o is 0, and no edge blanks the trigger.
- R2: A write with both protect flags clear stores data bits 19,18,17,16 as the enables for high-rising, high-falling, low-rising and low-falling edges, and data bits 6..0 as the duration N. Readback returns those bits in the same positions, with every other bit read as 0.
- R3: A write is ignored, and readback stays unchanged, while wp_sw_i or wp_hw_i is 1.
- R4: Outside a blanking window, trig_o in cycle k+1 equals trig_i in cycle k.
- R5: An enabled edge with N of 2 or more blanks trig_o for exactly N-1 consecutive cycles. The edge cycle is the first cycle in which the PWM input shows its new level. The blanked trigger samples run from the edge cycle through N-2 cycles after it.
- R6: An edge whose enable bit is 0 starts no blanking.
- R7: A duration field of 0 or 1 produces no blanking, even for enabled edges.
- R8: An enabled edge inside an active window restarts the window from that edge. The blanked span therefore ends N-2 cycles after the later edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| trig_i | input | 1 | Raw external trigger |
| pwm_h_i | input | 1 | High-side PWM output level |
| pwm_l_i | input | 1 | Low-side PWM output level |
| wr_en_i | input | 1 | Register write strobe |
| wr_data_i | input | 32 | Register write data |
| wp_sw_i | input | 1 | Software write-protect status |
| wp_hw_i | input | 1 | Hardware write-protect status |
| rd_data_o | output | 32 | Register readback |
| trig_o | output | 1 | Blanked trigger, registered |

## Verification
The assertions check several properties on every cycle: a blanked cycle yields a low output, an unblanked cycle passes the trigger one cycle late, the counter steps down by one without an edge, protected writes leave the readback stable, and short durations load an empty window. The exact width of each window against N can only be shown by the bench's scenarios. So can the selectivity of each enable mask over all four edge types, and the span produced when one window is extended by a second edge. The bench sweeps every enable mask, every edge type and a spread of durations, and counts the blanked output cycles.

// File: rtl/leb_pkg.sv
package leb_pkg;
  localparam int NUM_EDGES = 4;

  // bit order matches register bits 19..16
  typedef struct packed {
    logic h_rise;
    logic h_fall;
    logic l_rise;
    logic l_fall;
  } leb_edges_t;
endpackage

// File: rtl/leb_cfg_reg.sv
module leb_cfg_reg
  import leb_pkg::*;
#(
  parameter int REG_W  = 32,
  parameter int DLY_W  = 7,
  parameter int EN_LSB = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [REG_W-1:0] wr_data_i,
  input  logic             wp_sw_i,
  input  logic             wp_hw_i,
  output leb_edges_t       en_o,
  output logic [DLY_W-1:0] dly_o,
  output logic [REG_W-1:0] rd_data_o
);
  logic       wr_ok;
  leb_edges_t en_q;
  logic [DLY_W-1:0] dly_q;

  assign wr_ok = wr_en_i & ~wp_sw_i & ~wp_hw_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q  <= '0;
      dly_q <= '0;
    end else if (wr_ok) begin
      en_q  <= wr_data_i[EN_LSB +: NUM_EDGES];
      dly_q <= wr_data_i[DLY_W-1:0];
    end
  end

  always_comb begin
    rd_data_o = '0;
    rd_data_o[EN_LSB +: NUM_EDGES] = en_q;
    rd_data_o[DLY_W-1:0] = dly_q;
  end

  assign en_o  = en_q;
  assign dly_o = dly_q;

  AST_WP_BLOCK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && (wp_sw_i || wp_hw_i)) |=> $stable(rd_data_o)); // R3
  AST_WR_TAKE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && !wp_sw_i && !wp_hw_i) |=>
      rd_data_o[DLY_W-1:0] == $past(wr_data_i[DLY_W-1:0])); // R2
endmodule

// File: rtl/leb_edge_det.sv
module leb_edge_det #(
  parameter int N_CH = 2
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [N_CH-1:0] pwm_i,
  output logic [N_CH-1:0] rise_o,
  output logic [N_CH-1:0] fall_o
);
  for (genvar g = 0; g < N_CH; g++) begin : g_ch
    logic prev_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) prev_q <= 1'b0;
      else         prev_q <= pwm_i[g];
    end
    assign rise_o[g] = pwm_i[g] & ~prev_q;
    assign fall_o[g] = ~pwm_i[g] & prev_q;

    AST_RISE_SEEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(pwm_i[g]) |-> rise_o[g]); // R5
  end
endmodule

// File: rtl/leb_window.sv
module leb_window #(
  parameter int DLY_W = 7
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             edge_i,
  input  logic [DLY_W-1:0] dly_i,
  output logic             blank_o
);
  localparam logic [DLY_W-1:0] MIN_DLY = DLY_W'(2);

  logic [DLY_W-1:0] cnt_q, load_val;
  logic             long_dly;

  // field N blanks N-1 cycles: edge cycle plus N-2 counted cycles
  assign long_dly = dly_i >= MIN_DLY;
  assign load_val = long_dly ? dly_i - MIN_DLY : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (edge_i)        cnt_q <= load_val;
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign blank_o = (edge_i & long_dly) | (cnt_q != '0);

  AST_CNT_DOWN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!edge_i && cnt_q != '0) |=> cnt_q == $past(cnt_q) - 1'b1); // R5
  AST_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!edge_i && cnt_q == '0) |=> cnt_q == '0); // R6
  AST_SHORT_DLY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (edge_i && dly_i < MIN_DLY) |=> cnt_q == '0); // R7
endmodule

// File: rtl/leb_unit.sv
module leb_unit
  import leb_pkg::*;
#(
  parameter int REG_W  = 32,
  parameter int DLY_W  = 7,
  parameter int EN_LSB = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             trig_i,
  input  logic             pwm_h_i,
  input  logic             pwm_l_i,
  input  logic             wr_en_i,
  input  logic [REG_W-1:0] wr_data_i,
  input  logic             wp_sw_i,
  input  logic             wp_hw_i,
  output logic [REG_W-1:0] rd_data_o,
  output logic             trig_o
);
  localparam int N_CH = 2; // index 1 high side, 0 low side

  leb_edges_t       en;
  logic [DLY_W-1:0] dly;
  logic [N_CH-1:0]  rise, fall;
  leb_edges_t       seen;
  logic             qual, blank, trig_q;

  leb_cfg_reg #(.REG_W(REG_W), .DLY_W(DLY_W), .EN_LSB(EN_LSB)) u_cfg (
    .clk_i, .rst_ni, .wr_en_i, .wr_data_i, .wp_sw_i, .wp_hw_i,
    .en_o(en), .dly_o(dly), .rd_data_o
  );

  leb_edge_det #(.N_CH(N_CH)) u_edge (
    .clk_i, .rst_ni, .pwm_i({pwm_h_i, pwm_l_i}), .rise_o(rise), .fall_o(fall)
  );

  assign seen = '{h_rise: rise[1], h_fall: fall[1], l_rise: rise[0], l_fall: fall[0]};
  assign qual = |(seen & en);

  leb_window #(.DLY_W(DLY_W)) u_win (
    .clk_i, .rst_ni, .edge_i(qual), .dly_i(dly), .blank_o(blank)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) trig_q <= 1'b0;
    else         trig_q <= trig_i & ~blank;
  end
  assign trig_o = trig_q;

  AST_BLANK_MASK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    blank |=> !trig_o); // R5
  AST_PASS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !blank |=> trig_o == $past(trig_i)); // R4
endmodule

// File: tb/leb_unit_tb.sv
module leb_unit_tb_top;
  localparam int CLK_P = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic trig = 1'b0, pwm_h = 1'b0, pwm_l = 1'b0;
  logic wr_en = 1'b0, wp_sw = 1'b0, wp_hw = 1'b0;
  logic [31:0] wr_data = '0, rd_data;
  logic trig_out;
  int n_chk = 0, n_bad = 0;

  always #(CLK_P/2) clk = ~clk;

  leb_unit dut_i (
    .clk_i(clk), .rst_ni(rst_n), .trig_i(trig), .pwm_h_i(pwm_h), .pwm_l_i(pwm_l),
    .wr_en_i(wr_en), .wr_data_i(wr_data), .wp_sw_i(wp_sw), .wp_hw_i(wp_hw),
    .rd_data_o(rd_data), .trig_o(trig_out)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [31:0] d, input logic sw, input logic hw);
    @(negedge clk);
    wr_en = 1'b1; wr_data = d; wp_sw = sw; wp_hw = hw;
    @(negedge clk);
    wr_en = 1'b0; wp_sw = 1'b0; wp_hw = 1'b0;
  endtask

  function automatic int dly_of(input int i);
    case (i)
      0: return 0;  1: return 1;  2: return 2;  3: return 3;
      4: return 7;  5: return 64; default: return 127;
    endcase
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    int lows;
    logic prev;
    logic [7:0] lfsr;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 reset readback", rd_data, 32'h0);
    chk("R1 reset trig_o", {31'b0, trig_out}, 32'h0);

    // R1: no blanking out of reset
    trig = 1'b1; pwm_h = 1'b1;
    lows = 0;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      if (!trig_out) lows++;
      if (i == 2) pwm_l = 1'b1;
    end
    chk("R1 no blanking after reset", lows, 0);
    pwm_h = 1'b0; pwm_l = 1'b0;

    // R2: field placement and readback
    wr(32'hFFFF_FFFF, 1'b0, 1'b0);
    chk("R2 all ones readback", rd_data, 32'h000F_007F);
    wr(32'hA5A5_5A5A, 1'b0, 1'b0);
    chk("R2 pattern readback", rd_data, 32'h0005_005A);

    // R3: protected writes
    wr(32'hFFFF_FFFF, 1'b1, 1'b0);
    chk("R3 sw protect", rd_data, 32'h0005_005A);
    wr(32'h0000_0000, 1'b0, 1'b1);
    chk("R3 hw protect", rd_data, 32'h0005_005A);
    wr(32'h000A_0011, 1'b1, 1'b1);
    chk("R3 both protect", rd_data, 32'h0005_005A);
    wr(32'h000A_0011, 1'b0, 1'b0);
    chk("R3 unprotected after", rd_data, 32'h000A_0011);

    // R4: pass-through with enables off, PWM toggling
    wr(32'h0000_0014, 1'b0, 1'b0);
    lfsr = 8'h5B;
    for (int i = 0; i < 120; i++) begin
      @(negedge clk);
      if (i > 0) chk("R4 pass latency", {31'b0, trig_out}, {31'b0, prev});
      lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      trig = lfsr[0];
      pwm_h = lfsr[2];
      pwm_l = ~lfsr[2];
      prev = trig;
    end

    // R5/R6/R7: every mask x edge type x duration
    trig = 1'b1;
    for (int m = 0; m < 16; m++) begin
      for (int e = 0; e < 4; e++) begin
        for (int ni = 0; ni < 7; ni++) begin
          int n, exp_lows;
          logic en;
          n = dly_of(ni);
          en = m[3-e];
          wr(32'h0, 1'b0, 1'b0);
          @(negedge clk);
          pwm_h = (e == 1); // falling edges start high
          pwm_l = (e == 3);
          repeat (3) @(negedge clk);
          wr((32'(m) << 16) | 32'(n), 1'b0, 1'b0);
          repeat (2) @(negedge clk);
          if (e < 2) pwm_h = ~pwm_h; else pwm_l = ~pwm_l;
          lows = 0;
          repeat (n + 6) begin
            @(negedge clk);
            if (!trig_out) lows++;
          end
          exp_lows = (en && n >= 2) ? n - 1 : 0;
          if (!en)         chk("R6 disabled edge", lows, exp_lows);
          else if (n < 2)  chk("R7 short duration", lows, exp_lows);
          else             chk("R5 window length", lows, exp_lows);
        end
      end
    end

    // R8: second edge extends window (N=10, edges 4 cycles apart -> 13)
    wr(32'h0, 1'b0, 1'b0);
    @(negedge clk);
    pwm_h = 1'b0; pwm_l = 1'b1;
    repeat (3) @(negedge clk);
    wr(32'h0009_000A, 1'b0, 1'b0);
    repeat (2) @(negedge clk);
    pwm_h = 1'b1;
    lows = 0;
    for (int i = 0; i < 30; i++) begin
      @(negedge clk);
      if (!trig_out) lows++;
      if (i == 3) pwm_l = 1'b0;
    end
    chk("R8 window restart", lows, 13);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule